// File: doc/BRIEF.md
# Tick-Counting Watchdog

This block guards against runaway software. An upstream timer delivers a one-cycle periodic tick at the selected rate. The watchdog divides that tick by eight with a small counter. If software fails to service it before the eighth tick, the block emits a reset request. That request is meant to reach the reset controller, which handles it the same way as an ordinary reset.

Software services the watchdog by writing to one fixed register-bus address with data bit 0 cleared. A service clears only the divide-by-eight stage; the upstream tick source keeps running untouched. With a 3 MHz operating clock and tick divisors from 2^14 to 2^17, the timeout comes to roughly 43.7 ms, 87.4 ms, 174.8 ms or 349.5 ms.

Whether the watchdog exists at all is fixed when the design is built. Without it, the reset request is tied inactive.

Top module: `wdt_tick_watchdog`

## Requirements
- R1: While `rstN` is low, `resetReq` is 0. On release the divide-by-eight counter starts at zero.
- R2: When no service intervenes, the eighth tick after the counter was last cleared raises `resetReq`. The pulse appears in the cycle after the clock edge that sampled that tick.
- R3: `resetReq` is a pulse exactly one clock cycle wide.
- R4: A bus write to address 0x1FF0 with data bit 0 equal to 0 clears the counter to zero. The other data bits do not matter. After a service, eight further ticks are needed for a timeout.
- R5: A write to 0x1FF0 with data bit 0 equal to 1 leaves the counter unchanged.
- R6: A write to any address other than 0x1FF0 leaves the counter unchanged.
- R7: When a service write and a tick occur in the same cycle, the service wins. The counter ends at zero and no pulse is produced.
- R8: Cycles without a tick do not advance the counter. After a timeout the counter wraps to zero, so the next timeout needs another eight ticks.
- R9: When the build-time option `PRESENT` is 0, `resetReq` is never asserted.
- R10: Asserting `rstN` in the middle of a count discards the partial count. Ticks that arrive while reset is held are also ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle periodic tick from the upstream timer |
| busWrEn | input | 1 | Register bus write strobe |
| busAddr | input | ADDR_W (16) | Register bus write address |
| busWrData | input | DATA_W (8) | Register bus write data |
| resetReq | output | 1 | One-cycle internal reset request |

## Verification
Every result of this block arrives one rising edge after the cycle of the stimulus that causes it. A tick, a service write or a reset change in cycle k shows up in the counter state and in `resetReq` right after edge k. The bench sets each cycle's inputs at the falling edge. It reads `resetReq` 1 ns after the next rising edge, so each observation matches exactly one stimulus cycle. Ignored writes are checked by counting the remaining ticks to the next pulse, which must arrive at the tick predicted from the last true clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Per-cycle commands from decode/control into the divider datapath.
  typedef struct packed {
    logic clearDiv;  // service accepted: zero the divide-by-eight stage
    logic advance;   // count one tick
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 16'h1FF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output wdtStrobe_t        stb
);
  logic addrHit;
  logic svcHit;

  assign addrHit = (busAddr == SVC_ADDR);
  // Only bit 0 of the data carries meaning; 0 means "service".
  assign svcHit  = busWrEn && addrHit && (busWrData[0] == 1'b0);

  always_comb begin
    stb          = '0;
    stb.clearDiv = svcHit;
    // A same-cycle service overrides the tick.
    stb.advance  = tick && !svcHit;
  end

  // R5: a write with bit 0 set never produces a clear
  a_r5_set_bit_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busWrData[0]) |-> !stb.clearDiv);

  // R6: writes elsewhere never produce a clear
  a_r6_other_addr_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != SVC_ADDR) |-> !stb.clearDiv);

  // R7: a tick alongside a service is not counted
  a_r7_service_beats_tick: assert property (@(posedge clk) disable iff (!rstN)
    (tick && stb.clearDiv) |-> !stb.advance);
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int DIV_BITS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  wdtStrobe_t stb,
  output logic       resetReq
);
  localparam logic [DIV_BITS-1:0] DIV_MAX = {DIV_BITS{1'b1}};

  logic [DIV_BITS-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= 1'b0;
      if (stb.clearDiv) begin
        divCnt <= '0;
      end else if (stb.advance) begin
        divCnt <= divCnt + 1'b1;  // wraps to zero at terminal count
        if (divCnt == DIV_MAX) resetReq <= 1'b1;
      end
    end
  end

  // R3: request lasts one cycle
  a_r3_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  // R2: a request follows only a counted tick at terminal count
  a_r2_pulse_from_terminal: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> ($past(stb.advance) && ($past(divCnt) == DIV_MAX)));

  // R4: a clear leaves a zero count and no request
  a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearDiv |=> ((divCnt == '0) && !resetReq));

  // R8: idle cycles hold the count
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clearDiv && !stb.advance) |=> $stable(divCnt));
endmodule

// File: rtl/wdt_tick_watchdog.sv
module wdt_tick_watchdog
  import wdt_pkg::*;
#(
  parameter bit PRESENT = 1'b1,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DIV_BITS = 3,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 16'h1FF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic              resetReq
);
  generate
    if (PRESENT) begin : g_wdt
      wdtStrobe_t stb;

      wdt_ctrl #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SVC_ADDR(SVC_ADDR)
      ) u_ctrl (
        .clk      (clk),
        .rstN     (rstN),
        .tick     (tick),
        .busWrEn  (busWrEn),
        .busAddr  (busAddr),
        .busWrData(busWrData),
        .stb      (stb)
      );

      wdt_datapath #(
        .DIV_BITS(DIV_BITS)
      ) u_dp (
        .clk     (clk),
        .rstN    (rstN),
        .stb     (stb),
        .resetReq(resetReq)
      );
    end else begin : g_absent
      // R9: without the option the request is held inactive
      assign resetReq = 1'b0;
    end
  endgenerate
endmodule

// File: tb/wdt_tick_watchdog_bench.sv
`timescale 1ns/1ps
module wdt_tick_watchdog_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        busWrEn = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        resetReq;
  logic        resetReqOff;

  int vecCount = 0;
  int failCount = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  wdt_tick_watchdog u_wdt_tick_watchdog (
    .clk(clk), .rstN(rstN), .tick(tick), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .resetReq(resetReq)
  );

  wdt_tick_watchdog #(.PRESENT(1'b0)) u_off (
    .clk(clk), .rstN(rstN), .tick(tick), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .resetReq(resetReqOff)
  );

  // Row: {repeat[34:27], tick[26], wr[25], addr[24:9], data[8:1], expReq[0]}
  localparam int NROWS = 13;
  localparam logic [34:0] VEC [NROWS] = '{
    {8'd7, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b0},  // R2 seven ticks: quiet
    {8'd1, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b1},  // R2 eighth tick: pulse
    {8'd2, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0},  // R3 pulse gone, R8 idle
    {8'd3, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b0},  // R8 count resumes from 0
    {8'd1, 1'b0, 1'b1, 16'h1FF0, 8'hFE, 1'b0},  // R4 service, upper bits set
    {8'd7, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b0},  // R4 seven ticks after clear
    {8'd1, 1'b0, 1'b1, 16'h1FF0, 8'h01, 1'b0},  // R5 bit0=1 write
    {8'd1, 1'b0, 1'b1, 16'h1FF1, 8'h00, 1'b0},  // R6 wrong address
    {8'd1, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b1},  // R5 R6 count kept: pulse
    {8'd5, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b0},  // five ticks
    {8'd1, 1'b1, 1'b1, 16'h1FF0, 8'h00, 1'b0},  // R7 tick with service
    {8'd7, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b0},  // R7 counter was zeroed
    {8'd1, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b1}   // R7 eighth tick: pulse
  };

  task automatic check(input logic act, input logic exp, input string req);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: resetReq=%b expected %b at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic t, input logic w, input logic [15:0] a,
                      input logic [7:0] d);
    @(negedge clk);
    tick = t; busWrEn = w; busAddr = a; busWrData = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        failCount++;
        $display("FAIL watchdog: run hung, cycles=%0d expected below 20000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
        $finish;
      end
    end
  end

  initial begin
    // R1: reset state, with ticks offered during reset
    repeat (3) step(1'b1, 1'b0, 16'h0, 8'h0);
    check(resetReq, 1'b0, "R1");
    check(resetReqOff, 1'b0, "R9");
    @(negedge clk);
    tick = 1'b0;
    rstN = 1'b1;

    // Vector table walk
    for (int r = 0; r < NROWS; r++) begin
      for (int k = 0; k < int'(VEC[r][34:27]); k++) begin
        step(VEC[r][26], VEC[r][25], VEC[r][24:9], VEC[r][8:1]);
        check(resetReq, VEC[r][0], "R2/R3/R4/R5/R6/R7/R8 table");
        check(resetReqOff, 1'b0, "R9");
      end
    end

    // R10: reset mid-count discards the partial count
    repeat (5) begin
      step(1'b1, 1'b0, 16'h0, 8'h0);
      check(resetReq, 1'b0, "R10 pre-reset");
    end
    @(negedge clk);
    rstN = 1'b0;
    repeat (4) begin
      step(1'b1, 1'b0, 16'h0, 8'h0);
      check(resetReq, 1'b0, "R10 in reset");
    end
    @(negedge clk);
    tick = 1'b0;
    rstN = 1'b1;
    repeat (7) begin
      step(1'b1, 1'b0, 16'h0, 8'h0);
      check(resetReq, 1'b0, "R10 after reset");
      check(resetReqOff, 1'b0, "R9");
    end
    step(1'b1, 1'b0, 16'h0, 8'h0);
    check(resetReq, 1'b1, "R10 eighth tick after reset");
    step(1'b0, 1'b0, 16'h0, 8'h0);
    check(resetReq, 1'b0, "R3 pulse width");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule